// File: doc/BRIEF.md
# Register state image restore sequencer

This block reloads the floating-point and vector register bank of a core from a 512-byte save image in memory. A single `start_i` pulse hands it the image base address, the current operating mode and the relevant control inputs: task-switched, emulation, feature present, lock prefix, alignment-check enable and privilege level. It first screens the request for faults in a fixed priority order. If the screen passes, it streams the image over a 128-bit read port, one 16-byte beat per cycle, and stages every beat. It checks the control/status word when that beat arrives. Only after every check has passed does it commit the staged beats to the register file and to the control/status register.

The controller is a single state machine with these states: `S_IDLE` (waits for start), `S_SCREEN` (evaluates the pre-load faults), `S_FETCH` (issues reads and collects beats), `S_DRAIN` (waits for outstanding reads after a reserved-bit violation), `S_COMMIT` (one write per staged beat) and `S_DONE` (a one-cycle completion pulse). The transitions are:

- `S_IDLE` goes to `S_SCREEN` on start.
- `S_SCREEN` goes to `S_DONE` on a fault. Otherwise it goes to `S_FETCH`.
- `S_FETCH` goes to `S_DRAIN` on a reserved-bit violation. It goes to `S_COMMIT` when the last beat arrives.
- `S_DRAIN` goes to `S_DONE` once no reads remain outstanding.
- `S_COMMIT` goes to `S_DONE` after the last beat.
- `S_DONE` goes to `S_IDLE`.

Top module: `regimg_restore`

## Requirements
- R1: When `base_i[3:0]` is nonzero, the sequencer finishes with fault code 3 (general protection) and issues no read. If `acchk_i` is 1 and `cpl_i` is 3, it finishes with code 4 (alignment check) instead.
- R2: When `feat_ok_i` is 0 or `lock_i` is 1, the sequencer finishes with code 1 (invalid opcode) and issues no read. This check outranks every other fault.
- R3: When `task_sw_i` or `emul_i` is 1, the sequencer finishes with code 2 (device not available) and issues no read. This check outranks every address fault.
- R4: The control/status word sits at image bytes 24..27, which are bits 95:64 of beat 1. If any bit of its upper half (bits 16..31) is set, the sequencer finishes with code 3 and performs no register-file write and no control/status load.
- R5: No read is ever issued at an offset of 464 or more from the image base.
- R6: `mode_i`=2 selects 64-bit mode, which commits 16 vector registers (kind 2, index 0..15). Other modes commit 8. Vector register i comes from image offset 160+16·i.
- R7: With `mode_i`=0 (real-address mode), an image whose last byte lies above address FFFFh finishes with code 3. A base of FE00h is accepted.
- R8: With `mode_i`=2, a base whose bits 63..47 are not all equal finishes with code 3.
- R9: On success, one write is made per cycle in ascending beat order:
  - beat 0 goes out as kind 0, index 0;
  - beat 1 performs the control/status load of image bytes 24..25;
  - eight stack registers follow as kind 1, index i, carrying bits 79:0 of offset 32+16·i.
  After the writes, `done_o` pulses for one cycle with code 0.
- R10: A control/status word whose exception flags are set while their masks are clear loads normally and finishes with code 0.
- R11: After reset, `done_o`, `rd_en_o`, `rf_we_o` and `csr_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to restore |
| base_i | input | ADDR_W | Image base address |
| mode_i | input | 2 | 0 real-address, 1 protected, 2 64-bit |
| task_sw_i | input | 1 | Task-switched control bit |
| emul_i | input | 1 | Emulation control bit |
| feat_ok_i | input | 1 | Save/restore feature present |
| lock_i | input | 1 | Lock prefix present |
| acchk_i | input | 1 | Alignment checking enabled |
| cpl_i | input | 2 | Current privilege level |
| rd_en_o | output | 1 | Read request, one beat |
| rd_addr_o | output | ADDR_W | Read address, 16-byte aligned |
| rd_valid_i | input | 1 | Read data valid, in request order |
| rd_data_i | input | 128 | Read data beat, byte 0 in bits 7:0 |
| rf_we_o | output | 1 | Register-file write enable |
| rf_kind_o | output | 2 | 0 environment, 1 stack, 2 vector |
| rf_idx_o | output | IDX_W | Register index within kind |
| rf_data_o | output | 128 | Write data |
| csr_we_o | output | 1 | Control/status register load |
| csr_data_o | output | 16 | Control/status value loaded |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 3 | 0 none, 1 invalid opcode, 2 not available, 3 general protection, 4 alignment |

## Verification
The embedded assertions watch every cycle for the following:
- every read address is 16-byte aligned;
- no read reaches the ignored tail of the image;
- vector indices stay within the count for the mode;
- the completion pulse lasts exactly one cycle;
- a screening fault leaves the read issue count at zero.

The fault priority order, the exact commit sequence and its data, the real-address and canonical limits, and the absence of writes after a reserved-bit violation can only be shown by the bench's scenarios. The bench checks them against a scoreboard of expected writes.

// File: rtl/regimg_pkg.sv
package regimg_pkg;
    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_NM   = 3'd2,
        FLT_GP   = 3'd3,
        FLT_AC   = 3'd4
    } fault_e;

    localparam logic [1:0] MODE_REAL = 2'd0;
    localparam logic [1:0] MODE_PROT = 2'd1;
    localparam logic [1:0] MODE_LONG = 2'd2;

    localparam logic [1:0] KIND_ENV = 2'd0;
    localparam logic [1:0] KIND_STK = 2'd1;
    localparam logic [1:0] KIND_VEC = 2'd2;

    localparam int BEAT_W     = 128;
    localparam int BEAT_LSB   = 4;
    localparam int IMG_BYTES  = 512;
    localparam int TAIL_OFS   = 464;
    localparam int CSR_BEAT   = 1;
    localparam int CSR_LSB    = 64;
    localparam int STK_BEAT0  = 2;
    localparam int NUM_STK    = 8;
    localparam int STK_W      = 80;
    localparam int VEC_BEAT0  = STK_BEAT0 + NUM_STK;
endpackage

// File: rtl/regimg_screen.sv
module regimg_screen
    import regimg_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int VA_W   = 48
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        mode_i,
    input  logic              task_sw_i,
    input  logic              emul_i,
    input  logic              feat_ok_i,
    input  logic              lock_i,
    input  logic              acchk_i,
    input  logic [1:0]        cpl_i,
    output fault_e            fault_o
);
    localparam int UP_W = ADDR_W - VA_W + 1;

    logic            misaligned;
    logic [16:0]     real_end;
    logic            real_over;
    logic [UP_W-1:0] upper;
    logic            noncanon;

    assign misaligned = |base_i[BEAT_LSB-1:0];
    assign real_end   = {1'b0, base_i[15:0]} + 17'(IMG_BYTES - 1);
    assign real_over  = (mode_i == MODE_REAL) && ((|base_i[ADDR_W-1:16]) || real_end[16]);
    assign upper      = base_i[ADDR_W-1:VA_W-1];
    assign noncanon   = (mode_i == MODE_LONG) && !((&upper) || !(|upper));

    // Ordered screen: opcode, device, alignment, address range
    always_comb begin
        if (!feat_ok_i || lock_i) begin
            fault_o = FLT_UD;
        end else if (task_sw_i || emul_i) begin
            fault_o = FLT_NM;
        end else if (misaligned) begin
            fault_o = (acchk_i && cpl_i == 2'd3) ? FLT_AC : FLT_GP;
        end else if (real_over || noncanon) begin
            fault_o = FLT_GP;
        end else begin
            fault_o = FLT_NONE;
        end
    end
endmodule

// File: rtl/regimg_beat_map.sv
module regimg_beat_map
    import regimg_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input  logic [CNT_W-1:0] beat_i,
    output logic             is_csr_o,
    output logic [1:0]       kind_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [CNT_W-1:0] B_CSR = CNT_W'(CSR_BEAT);
    localparam logic [CNT_W-1:0] B_STK = CNT_W'(STK_BEAT0);
    localparam logic [CNT_W-1:0] B_VEC = CNT_W'(VEC_BEAT0);

    always_comb begin
        is_csr_o = (beat_i == B_CSR);
        if (beat_i < B_STK) begin
            kind_o = KIND_ENV;
            idx_o  = '0;
        end else if (beat_i < B_VEC) begin
            kind_o = KIND_STK;
            idx_o  = IDX_W'(beat_i - B_STK);
        end else begin
            kind_o = KIND_VEC;
            idx_o  = IDX_W'(beat_i - B_VEC);
        end
    end
endmodule

// File: rtl/regimg_stage.sv
module regimg_stage #(
    parameter int DEPTH = 26,
    parameter int W     = 128,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/regimg_restore.sv
module regimg_restore
    import regimg_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int VA_W       = 48,
    parameter int VEC_WIDE   = 16,
    parameter int VEC_NARROW = 8,
    parameter int IDX_W      = $clog2(VEC_WIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [1:0]        mode_i,
    input  logic              task_sw_i,
    input  logic              emul_i,
    input  logic              feat_ok_i,
    input  logic              lock_i,
    input  logic              acchk_i,
    input  logic [1:0]        cpl_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [127:0]      rd_data_i,
    output logic              rf_we_o,
    output logic [1:0]        rf_kind_o,
    output logic [IDX_W-1:0]  rf_idx_o,
    output logic [127:0]      rf_data_o,
    output logic              csr_we_o,
    output logic [15:0]       csr_data_o,
    output logic              done_o,
    output logic [2:0]        fault_o
);
    localparam int MAX_BEATS = VEC_BEAT0 + VEC_WIDE;
    localparam int CNT_W     = $clog2(MAX_BEATS + 1);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(VEC_BEAT0 + VEC_WIDE - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(VEC_BEAT0 + VEC_NARROW - 1);
    localparam logic [CNT_W-1:0] CSR_IDX     = CNT_W'(CSR_BEAT);
    localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

    typedef enum logic [2:0] {
        S_IDLE, S_SCREEN, S_FETCH, S_DRAIN, S_COMMIT, S_DONE
    } state_e;

    state_e            state_q, state_d;
    fault_e            fault_q, scr_fault;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        mode_q;
    logic              task_sw_q, emul_q, feat_ok_q, lock_q, acchk_q;
    logic [1:0]        cpl_q;
    logic [CNT_W-1:0]  iss_q, rcv_q, cmt_q, last_w, rcv_inc;
    logic              rx_fetch, csr_bad, stage_we;
    logic [127:0]      stage_rd;
    logic              map_csr;
    logic [1:0]        map_kind;
    logic [IDX_W-1:0]  map_idx;

    regimg_screen #(.ADDR_W(ADDR_W), .VA_W(VA_W)) screen_i (
        .base_i(base_q), .mode_i(mode_q), .task_sw_i(task_sw_q), .emul_i(emul_q),
        .feat_ok_i(feat_ok_q), .lock_i(lock_q), .acchk_i(acchk_q), .cpl_i(cpl_q),
        .fault_o(scr_fault)
    );

    regimg_stage #(.DEPTH(MAX_BEATS), .W(BEAT_W), .AW(CNT_W)) stage_i (
        .clk(clk), .we_i(stage_we), .waddr_i(rcv_q), .wdata_i(rd_data_i),
        .raddr_i(cmt_q), .rdata_o(stage_rd)
    );

    regimg_beat_map #(.CNT_W(CNT_W), .IDX_W(IDX_W)) map_i (
        .beat_i(cmt_q), .is_csr_o(map_csr), .kind_o(map_kind), .idx_o(map_idx)
    );

    assign last_w    = (mode_q == MODE_LONG) ? LAST_WIDE : LAST_NARROW;
    assign rd_en_o   = (state_q == S_FETCH) && (iss_q <= last_w);
    assign rd_addr_o = base_q + (ADDR_W'(iss_q) << BEAT_LSB);
    assign rx_fetch  = rd_valid_i && (state_q == S_FETCH);
    // Reserved upper half of the control/status word, checked as its beat lands
    assign csr_bad   = rx_fetch && (rcv_q == CSR_IDX) &&
                       (|rd_data_i[CSR_LSB+31:CSR_LSB+16]);
    assign stage_we  = rx_fetch && !csr_bad;
    assign rcv_inc   = rcv_q + (rd_valid_i ? ONE : '0);

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_SCREEN;
            S_SCREEN: state_d = (scr_fault != FLT_NONE) ? S_DONE : S_FETCH;
            S_FETCH: begin
                if (csr_bad)                               state_d = S_DRAIN;
                else if (rd_valid_i && rcv_q == last_w)   state_d = S_COMMIT;
            end
            S_DRAIN:  if (rcv_inc == iss_q) state_d = S_DONE;
            S_COMMIT: if (cmt_q == last_w) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            fault_q   <= FLT_NONE;
            base_q    <= '0;
            mode_q    <= MODE_PROT;
            task_sw_q <= 1'b0;
            emul_q    <= 1'b0;
            feat_ok_q <= 1'b0;
            lock_q    <= 1'b0;
            acchk_q   <= 1'b0;
            cpl_q     <= 2'd0;
            iss_q     <= '0;
            rcv_q     <= '0;
            cmt_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                base_q    <= base_i;
                mode_q    <= mode_i;
                task_sw_q <= task_sw_i;
                emul_q    <= emul_i;
                feat_ok_q <= feat_ok_i;
                lock_q    <= lock_i;
                acchk_q   <= acchk_i;
                cpl_q     <= cpl_i;
                iss_q     <= '0;
                rcv_q     <= '0;
                cmt_q     <= '0;
                fault_q   <= FLT_NONE;
            end
            if (state_q == S_SCREEN) fault_q <= scr_fault;
            if (csr_bad)             fault_q <= FLT_GP;
            if (rd_en_o)             iss_q   <= iss_q + ONE;
            if (state_q == S_FETCH || state_q == S_DRAIN) rcv_q <= rcv_inc;
            if (state_q == S_COMMIT) cmt_q   <= cmt_q + ONE;
        end
    end

    // Outputs
    always_comb begin
        rf_we_o    = 1'b0;
        rf_kind_o  = map_kind;
        rf_idx_o   = map_idx;
        rf_data_o  = stage_rd;
        csr_we_o   = 1'b0;
        csr_data_o = stage_rd[CSR_LSB+15:CSR_LSB];
        done_o     = 1'b0;
        unique case (state_q)
            S_COMMIT: begin
                if (map_csr) csr_we_o = 1'b1;
                else         rf_we_o  = 1'b1;
                if (map_kind == KIND_STK) rf_data_o = {{(BEAT_W-STK_W){1'b0}}, stage_rd[STK_W-1:0]};
            end
            S_DONE:  done_o = 1'b1;
            default: ;
        endcase
    end
    assign fault_o = fault_q;

    a_r1_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_addr_o[BEAT_LSB-1:0] == '0));

    a_r5_no_tail_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> ((rd_addr_o - base_q) < ADDR_W'(TAIL_OFS)));

    a_r6_vec_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && rf_kind_o == KIND_VEC) |->
        (32'(rf_idx_o) < ((mode_q == MODE_LONG) ? VEC_WIDE : VEC_NARROW)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r2_screen_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (fault_q == FLT_UD || fault_q == FLT_NM || fault_q == FLT_AC))
        |-> (iss_q == '0));
endmodule

// File: tb/regimg_restore_tb.sv
module regimg_restore_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [63:0]  base_i = '0;
    logic [1:0]   mode_i = 2'd1;
    logic         task_sw_i = 1'b0, emul_i = 1'b0, feat_ok_i = 1'b1, lock_i = 1'b0;
    logic         acchk_i = 1'b0;
    logic [1:0]   cpl_i = 2'd0;
    logic         rd_en_o, rd_valid_i;
    logic [63:0]  rd_addr_o;
    logic [127:0] rd_data_i;
    logic         rf_we_o, csr_we_o, done_o;
    logic [1:0]   rf_kind_o;
    logic [3:0]   rf_idx_o;
    logic [127:0] rf_data_o;
    logic [15:0]  csr_data_o;
    logic [2:0]   fault_o;

    always #4 clk = ~clk;

    regimg_restore dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .mode_i(mode_i),
        .task_sw_i(task_sw_i), .emul_i(emul_i), .feat_ok_i(feat_ok_i), .lock_i(lock_i),
        .acchk_i(acchk_i), .cpl_i(cpl_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .rf_we_o(rf_we_o),
        .rf_kind_o(rf_kind_o), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o),
        .csr_we_o(csr_we_o), .csr_data_o(csr_data_o), .done_o(done_o), .fault_o(fault_o)
    );

    typedef struct {
        int           kind;   // 0 env, 1 stack, 2 vector, 3 csr load, 4 done
        int           idx;
        logic [127:0] data;
        int           req;
    } exp_t;

    exp_t         sbq[$];
    int           compared = 0;
    int           mismatched = 0;
    int           rd_count = 0;
    int           tail_hits = 0;
    bit           finished = 0;
    logic [127:0] img [0:31];
    logic [63:0]  cur_base = '0;
    logic [63:0]  offs;

    // Memory model: one-cycle read latency, in order
    assign offs = rd_addr_o - cur_base;
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_i <= 1'b0;
            rd_data_i  <= '0;
        end else begin
            rd_valid_i <= rd_en_o;
            rd_data_i  <= img[offs[8:4]];
            if (rd_en_o) begin
                rd_count <= rd_count + 1;
                if (offs >= 64'd464) tail_hits <= tail_hits + 1;
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic chk(input bit ok, input int req, input string what,
                       input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic sb_cmp(input int kind, input int idx, input logic [127:0] data);
        exp_t e;
        compared++;
        if (sbq.size() == 0) begin
            mismatched++;
            $display("FAIL R9 unexpected event: actual kind %0d idx %0d data %h expected none",
                     kind, idx, data);
        end else begin
            e = sbq.pop_front();
            if (e.kind != kind || e.idx != idx || e.data !== data) begin
                mismatched++;
                $display("FAIL R%0d event: actual %0d/%0d/%h expected %0d/%0d/%h",
                         e.req, kind, idx, data, e.kind, e.idx, e.data);
            end
        end
    endtask

    // Monitor: observes results away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rf_we_o)  sb_cmp(int'(rf_kind_o), int'(rf_idx_o), rf_data_o);
            if (csr_we_o) sb_cmp(3, 0, {112'h0, csr_data_o});
            if (done_o)   sb_cmp(4, 0, {125'h0, fault_o});
        end
    end

    task automatic push(input int kind, input int idx, input logic [127:0] data, input int req);
        exp_t e;
        e.kind = kind; e.idx = idx; e.data = data; e.req = req;
        sbq.push_back(e);
    endtask

    // Driver: builds the image, predicts the result, runs one restore
    task automatic run(input logic [63:0] base, input logic [1:0] mode, input bit ts,
                       input bit em, input bit feat, input bit lk, input bit ac,
                       input logic [1:0] cpl, input logic [31:0] mx, input int seed,
                       input int exp_fault, input int exp_reads, input int req);
        int last;
        int waited;
        for (int b = 0; b < 32; b++)
            img[b] = {32'(seed), 32'(b), 32'hA5A50000 ^ 32'(b * 7), 32'(seed + b * 3)};
        img[1][95:64] = mx;
        cur_base = base;
        last = (mode == 2'd2) ? 25 : 17;
        if (exp_fault == 0) begin
            push(0, 0, img[0], 9);                                   // R9 env beat
            push(3, 0, {112'h0, mx[15:0]}, 9);                       // R9 csr load
            for (int i = 0; i < 8; i++) push(1, i, {48'h0, img[2 + i][79:0]}, 9);
            for (int v = 0; v <= last - 10; v++) push(2, v, img[10 + v], 6); // R6
        end
        push(4, 0, 128'(exp_fault), req);
        @(negedge clk);
        rd_count = 0; tail_hits = 0;
        base_i = base; mode_i = mode; task_sw_i = ts; emul_i = em; feat_ok_i = feat;
        lock_i = lk; acchk_i = ac; cpl_i = cpl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, req, "pending expected events", sbq.size(), 0);
        sbq.delete();
        if (exp_reads >= 0) chk(rd_count == exp_reads, req, "reads issued", rd_count, exp_reads);
        else                chk(rd_count > 0, req, "reads before reserved check", rd_count, 1);
        chk(tail_hits == 0, 5, "tail reads (R5)", tail_hits, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!done_o && !rd_en_o && !rf_we_o && !csr_we_o, 11, "outputs under reset",
            {done_o, rd_en_o, rf_we_o, csr_we_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !rd_en_o, 11, "idle after reset", {done_o, rd_en_o}, 0);

        // R9 R6: protected mode success, 8 vectors
        run(64'h1000, 2'd1, 0, 0, 1, 0, 0, 2'd0, 32'h1F80, 1, 0, 18, 9);
        // R6: 64-bit mode, canonical high address, 16 vectors
        run(64'h0000_7FFF_FFFF_F000, 2'd2, 0, 0, 1, 0, 0, 2'd0, 32'h1F80, 2, 0, 26, 6);
        // R6: 64-bit mode, canonical negative half
        run(64'hFFFF_8000_0000_0100, 2'd2, 0, 0, 1, 0, 0, 2'd3, 32'h0000, 3, 0, 26, 6);
        // R2: feature missing, also misaligned and task-switched
        run(64'h1004, 2'd1, 1, 0, 0, 0, 0, 2'd0, 32'h0, 4, 1, 0, 2);
        // R2: lock prefix outranks device-not-available
        run(64'h1000, 2'd1, 1, 1, 1, 1, 0, 2'd0, 32'h0, 5, 1, 0, 2);
        // R3: task-switched bit
        run(64'h1000, 2'd1, 1, 0, 1, 0, 0, 2'd0, 32'h0, 6, 2, 0, 3);
        // R3: emulation bit outranks misalignment
        run(64'h1008, 2'd1, 0, 1, 1, 0, 1, 2'd3, 32'h0, 7, 2, 0, 3);
        // R1: misaligned, privilege 0 -> general protection
        run(64'h1001, 2'd1, 0, 0, 1, 0, 1, 2'd0, 32'h0, 8, 3, 0, 1);
        // R1: misaligned, alignment check at privilege 3 -> alignment fault
        run(64'h100C, 2'd1, 0, 0, 1, 0, 1, 2'd3, 32'h0, 9, 4, 0, 1);
        // R1: misaligned at privilege 3 with checking off -> general protection
        run(64'h1002, 2'd2, 0, 0, 1, 0, 0, 2'd3, 32'h0, 10, 3, 0, 1);
        // R7: real mode, last byte exactly FFFFh accepted
        run(64'hFE00, 2'd0, 0, 0, 1, 0, 0, 2'd0, 32'h1F80, 11, 0, 18, 7);
        // R7: real mode overrun
        run(64'hFE10, 2'd0, 0, 0, 1, 0, 0, 2'd0, 32'h1F80, 12, 3, 0, 7);
        // R8: non-canonical in 64-bit mode
        run(64'h0000_8000_0000_0000, 2'd2, 0, 0, 1, 0, 0, 2'd0, 32'h1F80, 13, 3, 0, 8);
        // R4: reserved bit 16 of the control/status word
        run(64'h2000, 2'd1, 0, 0, 1, 0, 0, 2'd0, 32'h0001_1F80, 14, 3, -1, 4);
        // R4: reserved bit 31, 64-bit mode
        run(64'h2000, 2'd2, 0, 0, 1, 0, 0, 2'd0, 32'h8000_0000, 15, 3, -1, 4);
        // R10: flag set with mask clear loads without fault
        run(64'h3000, 2'd1, 0, 0, 1, 0, 0, 2'd0, 32'h0000_0001, 16, 0, 18, 10);

        finished = 1;
        summary();
    end
endmodule